// File: doc/BRIEF.md
# Transmit Descriptor Ring Gather Engine

This block is the transmit side of a network DMA. Software builds a ring of descriptors in memory. Each descriptor is four 32-bit words at consecutive addresses: status, control (status2), buffer address and next pointer. Software programs the ring head and then writes the transmit control register with its enable bit set. The engine searches the ring for a descriptor it owns and copies that descriptor's buffer fragment into a local packet buffer. It hands the descriptor back to software by clearing the ownership bit in memory, and then follows the next pointer. When a fragment marked as the end of a frame has been gathered, the whole frame leaves on a byte stream, together with the checksum-request flag of that descriptor.

The memory port moves one word per request. A request is held until it is acknowledged, and read data arrives with the acknowledge. The walk ends at the first descriptor in the chain that is not owned, or when the initial search comes back to where it started. It also ends when a fragment would overflow the packet buffer. At the end of a walk that sent at least one frame, the engine raises a one-cycle completion pulse and clears the start bit of the control register.

Top module: `tx_ring_dma`

## Requirements
- R1: After reset the busy output, the stream valid output and the completion pulse are 0, and both registers read 0. The registers are selected by csr_addr: 0 is the list head and 1 is the control register.
- R2: A write of the control register stores the full word whenever the engine is idle. If bit 30 of the written word is 1, busy is high from the next cycle until the walk ends. With bit 30 clear, no walk starts.
- R3: The search begins at the list head and checks bit 31 of the status word, which means owned by the engine. An unowned descriptor leads to its next pointer. The search ends without sending anything when that next pointer is zero or equal to the head. A head of zero also ends the walk at once.
- R4: Fragment byte counts come from control bits [10:0]. Bytes are gathered in address order, with little-endian byte lanes within each memory word, and may start at any byte address. A frame is the concatenation of all fragments up to and including the one with control bit 30 set.
- R5: The frame's checksum-request flag is 1 when control bits [28:27] of its last descriptor are not both zero.
- R6: After each fragment, the status word is written back to the descriptor's address with bit 31 cleared and all other bits unchanged.
- R7: After each descriptor, the engine reads the descriptor at its next pointer. The walk ends as soon as a read descriptor is unowned.
- R8: The packet buffer holds 2048 bytes. If a fragment would bring the frame above that, the engine copies nothing of it and writes back that descriptor's status with bit 14 set and ownership kept. The walk then ends, and the partial frame is discarded.
- R9: When a walk has sent one or more frames, the completion output pulses for one cycle as busy falls and control bit 31 reads 0. With no frame sent, there is no pulse and control bit 31 is kept.
- R10: While busy, writes to either register are ignored.
- R11: The stream uses valid and ready. The last byte of a frame carries the last marker. While ready is low, valid, data, last and the checksum flag hold.
- R12: A memory request, with its address, direction and write data, stays asserted until the acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 1 | Register select: 0 list head, 1 transmit control |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_csum | output | 1 | Checksum request for the current frame |
| busy | output | 1 | A walk is in progress |
| irq_tx_done | output | 1 | One-cycle completion pulse |

## Verification
Busy is due exactly one cycle after the triggering register write, and the bench samples it on the next falling edge. A stream byte changes hands on the rising edge that follows a falling edge at which both valid and ready were seen high. The monitor therefore compares data, last and the checksum flag at that falling edge against the scoreboard, while a three-cycle ready pattern applies backpressure throughout. The completion pulse falls in the first cycle with busy low, so the bench waits two falling edges after busy drops. Only then does it compare the pulse count, the register readbacks and the written-back status words in the bench memory.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_RDDESC, W_EVAL, W_COPY, W_WBACK, W_EMIT, W_DONE
  } walk_st_e;

  localparam int OWN_BIT       = 31;
  localparam int LENERR_BIT    = 14;
  localparam int LAST_BIT      = 30;
  localparam int CSUM_LO       = 27;
  localparam int CSUM_HI       = 28;
  localparam int DMA_EN_BIT    = 30;
  localparam int DMA_START_BIT = 31;
endpackage

// File: rtl/tx_pkt_buf.sv
module tx_pkt_buf #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/tx_frame_emit.sv
module tx_frame_emit #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW:0]   len,
  input  logic          csum_in,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          out_csum,
  output logic          done
);
  logic          active_q, active_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [AW:0]   len_q, len_d;
  logic          csum_q, csum_d;
  logic          fire;

  assign rd_addr   = idx_q;
  assign out_valid = active_q;
  assign out_data  = rd_data;
  assign out_csum  = csum_q;
  assign out_last  = active_q && (({1'b0, idx_q} + 1'b1) == len_q);
  assign fire      = out_valid && out_ready;
  assign done      = fire && out_last;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    len_d    = len_q;
    csum_d   = csum_q;
    if (!active_q && start) begin
      active_d = 1'b1;
      idx_d    = '0;
      len_d    = len;
      csum_d   = csum_in;
    end else if (fire) begin
      if (out_last) active_d = 1'b0;
      else          idx_d    = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
      csum_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      len_q    <= len_d;
      csum_q   <= csum_d;
    end
  end

  // R11: a stalled byte holds everything the sink sees
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_last) && $stable(out_csum));
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import tx_ring_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int AW        = $clog2(BUF_BYTES),
  parameter int CNT_W     = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic          csr_addr,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          buf_we,
  output logic [AW-1:0] buf_waddr,
  output logic [7:0]    buf_wdata,
  output logic          emit_start,
  output logic [AW:0]   emit_len,
  output logic          emit_csum,
  input  logic          emit_done,
  output logic          busy,
  output logic          irq
);
  localparam int SUMW = (((AW + 1) > CNT_W) ? (AW + 1) : CNT_W) + 1;

  walk_st_e         st_q, st_d;
  logic [31:0]      cur_q, cur_d, start_q, start_d;
  logic [31:0]      stat_q, stat_d, baddr_q, baddr_d, next_q, next_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, bidx_q, bidx_d;
  logic             last_q, last_d, csum_q, csum_d;
  logic [1:0]       widx_q, widx_d;
  logic             follow_q, follow_d, sent_q, sent_d, lerr_q, lerr_d;
  logic [AW:0]      pkt_q, pkt_d;
  logic [31:0]      head_q, head_d, ctl1_q, ctl1_d;
  logic             irq_d;
  logic [31:0]      byte_addr;

  assign busy       = (st_q != W_IDLE);
  assign csr_rdata  = csr_addr ? ctl1_q : head_q;
  assign byte_addr  = baddr_q + 32'(bidx_q);
  assign mem_req    = (st_q == W_RDDESC) || (st_q == W_COPY) || (st_q == W_WBACK);
  assign mem_we     = (st_q == W_WBACK);
  assign mem_wdata  = lerr_q ? (stat_q | (32'd1 << LENERR_BIT))
                             : (stat_q & ~(32'd1 << OWN_BIT));
  assign buf_waddr  = pkt_q[AW-1:0] + AW'(bidx_q);
  assign buf_wdata  = mem_rdata[8*byte_addr[1:0] +: 8];
  assign emit_len   = pkt_q;
  assign emit_csum  = csum_q;

  always_comb begin
    case (st_q)
      W_RDDESC: mem_addr = cur_q + {28'd0, widx_q, 2'b00};
      W_COPY:   mem_addr = {byte_addr[31:2], 2'b00};
      default:  mem_addr = cur_q;
    endcase
  end

  always_comb begin
    st_d = st_q; cur_d = cur_q; start_d = start_q;
    stat_d = stat_q; baddr_d = baddr_q; next_d = next_q;
    cnt_d = cnt_q; bidx_d = bidx_q; last_d = last_q; csum_d = csum_q;
    widx_d = widx_q; follow_d = follow_q; sent_d = sent_q; lerr_d = lerr_q;
    pkt_d = pkt_q; head_d = head_q; ctl1_d = ctl1_q;
    irq_d = 1'b0; buf_we = 1'b0; emit_start = 1'b0;
    case (st_q)
      W_IDLE: if (csr_we) begin
        if (!csr_addr) head_d = csr_wdata;
        else begin
          ctl1_d = csr_wdata;
          if (csr_wdata[DMA_EN_BIT]) begin
            cur_d = head_q; start_d = head_q; follow_d = 1'b0;
            sent_d = 1'b0; pkt_d = '0; widx_d = '0;
            st_d = (head_q == '0) ? W_DONE : W_RDDESC;
          end
        end
      end
      W_RDDESC: if (mem_ack) begin
        case (widx_q)
          2'd0: stat_d = mem_rdata;
          2'd1: begin
            cnt_d  = mem_rdata[CNT_W-1:0];
            last_d = mem_rdata[LAST_BIT];
            csum_d = |mem_rdata[CSUM_HI:CSUM_LO];
          end
          2'd2: baddr_d = mem_rdata;
          default: next_d = mem_rdata;
        endcase
        widx_d = widx_q + 2'd1;
        if (widx_q == 2'd3) st_d = W_EVAL;
      end
      W_EVAL: begin
        lerr_d = 1'b0;
        bidx_d = '0;
        if (stat_q[OWN_BIT]) begin
          if (SUMW'(pkt_q) + SUMW'(cnt_q) > SUMW'(BUF_BYTES)) begin
            lerr_d = 1'b1;
            st_d   = W_WBACK;
          end else begin
            st_d = (cnt_q == '0) ? W_WBACK : W_COPY;
          end
        end else if (follow_q || next_q == start_q || next_q == '0) begin
          st_d = W_DONE;
        end else begin
          cur_d = next_q; widx_d = '0; st_d = W_RDDESC;
        end
      end
      W_COPY: if (mem_ack) begin
        buf_we = 1'b1;
        bidx_d = bidx_q + 1'b1;
        if (bidx_q == cnt_q - 1'b1) begin
          pkt_d = pkt_q + (AW + 1)'(cnt_q);
          st_d  = W_WBACK;
        end
      end
      W_WBACK: if (mem_ack) begin
        if (lerr_q) st_d = W_DONE;
        else if (last_q && pkt_q != '0) begin
          emit_start = 1'b1;
          st_d = W_EMIT;
        end else begin
          if (last_q) begin sent_d = 1'b1; pkt_d = '0; end
          cur_d = next_q; follow_d = 1'b1; widx_d = '0; st_d = W_RDDESC;
        end
      end
      W_EMIT: if (emit_done) begin
        sent_d = 1'b1; pkt_d = '0;
        cur_d = next_q; follow_d = 1'b1; widx_d = '0; st_d = W_RDDESC;
      end
      default: begin
        if (sent_q) begin
          ctl1_d[DMA_START_BIT] = 1'b0;
          irq_d = 1'b1;
        end
        st_d = W_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; cur_q <= '0; start_q <= '0;
      stat_q <= '0; baddr_q <= '0; next_q <= '0;
      cnt_q <= '0; bidx_q <= '0; last_q <= 1'b0; csum_q <= 1'b0;
      widx_q <= '0; follow_q <= 1'b0; sent_q <= 1'b0; lerr_q <= 1'b0;
      pkt_q <= '0; head_q <= '0; ctl1_q <= '0; irq <= 1'b0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; start_q <= start_d;
      stat_q <= stat_d; baddr_q <= baddr_d; next_q <= next_d;
      cnt_q <= cnt_d; bidx_q <= bidx_d; last_q <= last_d; csum_q <= csum_d;
      widx_q <= widx_d; follow_q <= follow_d; sent_q <= sent_d; lerr_q <= lerr_d;
      pkt_q <= pkt_d; head_q <= head_d; ctl1_q <= ctl1_d; irq <= irq_d;
    end
  end

  // R12: an unanswered request keeps its address and direction
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
      $stable(mem_wdata));
  // R8: the gathered byte count never exceeds the packet buffer
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_q <= (AW + 1)'(BUF_BYTES));
  // R9: the completion pulse only appears once the engine is idle
  a_r9_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy && $fell(busy));
  // R10: register writes during a walk leave the head untouched
  a_r10_head_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy && csr_we |=> $stable(head_q));
endmodule

// File: rtl/tx_ring_dma.sv
module tx_ring_dma #(
  parameter int BUF_BYTES = 2048,
  parameter int CNT_W     = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic        csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_csum,
  output logic        busy,
  output logic        irq_tx_done
);
  localparam int AW = $clog2(BUF_BYTES);

  logic          buf_we;
  logic [AW-1:0] buf_waddr, buf_raddr;
  logic [7:0]    buf_wdata, buf_rdata;
  logic          emit_start, emit_csum, emit_done;
  logic [AW:0]   emit_len;

  tx_ring_walker #(.BUF_BYTES(BUF_BYTES), .AW(AW), .CNT_W(CNT_W)) walker_i (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .emit_start(emit_start), .emit_len(emit_len), .emit_csum(emit_csum),
    .emit_done(emit_done), .busy(busy), .irq(irq_tx_done)
  );

  tx_pkt_buf #(.DEPTH(BUF_BYTES), .AW(AW)) pktbuf_i (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  tx_frame_emit #(.AW(AW)) emit_i (
    .clk(clk), .rst_n(rst_n), .start(emit_start), .len(emit_len),
    .csum_in(emit_csum), .rd_addr(buf_raddr), .rd_data(buf_rdata),
    .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data),
    .out_last(tx_last), .out_csum(tx_csum), .done(emit_done)
  );
endmodule

// File: tb/tx_ring_dma_tb_top.sv
module tx_ring_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic        csr_addr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        tx_valid, tx_last, tx_csum, busy, irq_tx_done;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  int checks = 0;
  int failures = 0;
  int irq_cnt = 0;
  int cyc = 0;
  logic [9:0] exp_q[$];
  logic [31:0] mem [0:1023];

  always #5 clk = ~clk;

  tx_ring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_csum(tx_csum), .busy(busy), .irq_tx_done(irq_tx_done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: set ready for the coming edge, then check the byte it moves.
  always @(negedge clk) begin
    cyc++;
    if (irq_tx_done) irq_cnt++;
    tx_ready = (cyc % 3) != 0;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected byte", {22'd0, tx_csum, tx_last, tx_data}, 32'd0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check({tx_csum, tx_last, tx_data} == e, "R4 R5 R11 stream byte",
              {22'd0, tx_csum, tx_last, tx_data}, {22'd0, e});
      end
    end
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  function automatic logic [7:0] get_byte(input int a);
    return mem[a >> 2][8*(a & 3) +: 8];
  endfunction

  task automatic put_byte(input int a, input logic [7:0] v);
    mem[a >> 2][8*(a & 3) +: 8] = v;
  endtask

  task automatic put_desc(input int a, input logic [31:0] s, input logic [31:0] s2,
                          input logic [31:0] b, input logic [31:0] n);
    mem[a >> 2] = s; mem[(a >> 2) + 1] = s2; mem[(a >> 2) + 2] = b; mem[(a >> 2) + 3] = n;
  endtask

  // Driver: pushes the expected bytes of one fragment.
  task automatic expect_frag(input int a, input int n, input bit last, input bit cs);
    for (int i = 0; i < n; i++)
      exp_q.push_back({cs, (last && i == n - 1), get_byte(a + i)});
  endtask

  task automatic fill(input int a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) put_byte(a + i, seed + 8'(i * 7));
  endtask

  task automatic csr_write(input logic sel, input logic [31:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = sel; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic sel, output logic [31:0] v);
    csr_addr = sel;
    #1 v = csr_rdata;
  endtask

  task automatic run_walk(input logic [31:0] v);
    csr_write(1'b1, v);
    check(busy === 1'b1, "R2 busy one cycle after trigger", {31'd0, busy}, 32'd1);
    while (busy) @(negedge clk);
    @(negedge clk); @(negedge clk);
    check(exp_q.size() == 0, "R4 all expected bytes sent", exp_q.size(), 0);
  endtask

  logic [31:0] rd;
  int irq_before;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && tx_valid === 1'b0 && irq_tx_done === 1'b0,
          "R1 reset outputs", {29'd0, busy, tx_valid, irq_tx_done}, 32'd0);
    csr_read(1'b1, rd); check(rd === 32'd0, "R1 control reset", rd, 0);
    csr_read(1'b0, rd); check(rd === 32'd0, "R1 head reset", rd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: no enable bit, value only stored
    csr_write(1'b1, 32'h8000_0000);
    check(busy === 1'b0, "R2 no walk without enable", {31'd0, busy}, 0);
    csr_read(1'b1, rd); check(rd === 32'h8000_0000, "R2 control stored", rd, 32'h8000_0000);

    // R4 R5 R6 R7: two fragments, unaligned first buffer, checksum request
    fill(32'h201, 5, 8'hA1); fill(32'h240, 3, 8'h30);
    put_desc(32'h100, 32'h8000_0000, (32'd1 << 29) | 32'd5, 32'h201, 32'h110);
    put_desc(32'h110, 32'h8000_0000, (32'd1 << 30) | (32'd1 << 27) | 32'd3, 32'h240, 32'h120);
    put_desc(32'h120, 32'h0, 32'h0, 32'h0, 32'h100);
    expect_frag(32'h201, 5, 1'b0, 1'b1); expect_frag(32'h240, 3, 1'b1, 1'b1);
    csr_write(1'b0, 32'h100);
    irq_before = irq_cnt;
    run_walk(32'hC000_0000);
    check(mem[32'h100 >> 2] === 32'h0, "R6 first status released", mem[32'h100 >> 2], 0);
    check(mem[32'h110 >> 2] === 32'h0, "R6 second status released", mem[32'h110 >> 2], 0);
    check(irq_cnt - irq_before == 1, "R9 one pulse", irq_cnt - irq_before, 1);
    csr_read(1'b1, rd); check(rd === 32'h4000_0000, "R9 start bit cleared", rd, 32'h4000_0000);

    // R3: skip an unowned head, find owned entry, follow back to unowned head
    fill(32'h260, 4, 8'h55);
    put_desc(32'h140, 32'h0, 32'h0, 32'h0, 32'h150);
    put_desc(32'h150, 32'h8000_0001, (32'd3 << 29) | 32'd4, 32'h260, 32'h140);
    expect_frag(32'h260, 4, 1'b1, 1'b0);
    csr_write(1'b0, 32'h140);
    irq_before = irq_cnt;
    run_walk(32'hC000_0000);
    check(mem[32'h150 >> 2] === 32'h1, "R3 R6 found entry released, bits kept",
          mem[32'h150 >> 2], 1);
    check(mem[32'h140 >> 2] === 32'h0, "R3 unowned head untouched", mem[32'h140 >> 2], 0);
    check(irq_cnt - irq_before == 1, "R9 pulse after search", irq_cnt - irq_before, 1);

    // R3 R9: fully unowned ring wraps, nothing sent
    put_desc(32'h180, 32'h0, 32'h0, 32'h0, 32'h190);
    put_desc(32'h190, 32'h0, 32'h0, 32'h0, 32'h180);
    csr_write(1'b0, 32'h180);
    irq_before = irq_cnt;
    run_walk(32'hC000_0000);
    check(irq_cnt == irq_before, "R3 no pulse on empty ring", irq_cnt - irq_before, 0);
    csr_read(1'b1, rd); check(rd === 32'hC000_0000, "R9 start bit kept", rd, 32'hC000_0000);

    // R8: second fragment would overflow the packet buffer
    fill(32'h300, 10, 8'h10);
    put_desc(32'h1C0, 32'h8000_0000, (32'd1 << 29) | 32'd10, 32'h300, 32'h1D0);
    put_desc(32'h1D0, 32'h8000_0000, (32'd1 << 30) | 32'd2047, 32'h400, 32'h1C0);
    csr_write(1'b0, 32'h1C0);
    irq_before = irq_cnt;
    run_walk(32'hC000_0000);
    check(mem[32'h1C0 >> 2] === 32'h0, "R8 fitting fragment released", mem[32'h1C0 >> 2], 0);
    check(mem[32'h1D0 >> 2] === 32'h8000_4000, "R8 length error flagged",
          mem[32'h1D0 >> 2], 32'h8000_4000);
    check(irq_cnt == irq_before, "R8 no frame no pulse", irq_cnt - irq_before, 0);

    // R7 R10 R11: two single-fragment frames, writes during the walk
    fill(32'h280, 6, 8'hC0); fill(32'h2A0, 2, 8'hE0);
    put_desc(32'h080, 32'h8000_0000, (32'd1 << 30) | (32'd1 << 28) | 32'd6, 32'h280, 32'h090);
    put_desc(32'h090, 32'h8000_0000, (32'd1 << 30) | 32'd2, 32'h2A0, 32'h0A0);
    put_desc(32'h0A0, 32'h0, 32'h0, 32'h0, 32'h080);
    expect_frag(32'h280, 6, 1'b1, 1'b1); expect_frag(32'h2A0, 2, 1'b1, 1'b0);
    csr_write(1'b0, 32'h080);
    irq_before = irq_cnt;
    csr_write(1'b1, 32'hC000_0000);
    check(busy === 1'b1, "R2 busy after trigger", {31'd0, busy}, 1);
    csr_write(1'b0, 32'h3F0);
    csr_write(1'b1, 32'h0000_1234);
    while (busy) @(negedge clk);
    @(negedge clk); @(negedge clk);
    check(exp_q.size() == 0, "R7 both frames sent", exp_q.size(), 0);
    check(irq_cnt - irq_before == 1, "R9 single pulse for two frames", irq_cnt - irq_before, 1);
    csr_read(1'b0, rd); check(rd === 32'h080, "R10 head write ignored", rd, 32'h080);
    csr_read(1'b1, rd); check(rd === 32'h4000_0000, "R10 control write ignored", rd, 32'h4000_0000);
    check(mem[32'h090 >> 2] === 32'h0, "R7 followed entry released", mem[32'h090 >> 2], 0);

    // R3: zero head ends at once
    csr_write(1'b0, 32'h0);
    irq_before = irq_cnt;
    run_walk(32'hC000_0000);
    check(irq_cnt == irq_before, "R3 zero head no pulse", irq_cnt - irq_before, 0);
    csr_read(1'b1, rd); check(rd === 32'hC000_0000, "R3 zero head keeps start", rd, 32'hC000_0000);

    finish_run();
  end
endmodule